// File: doc/BRIEF.md
# Per-CPU Highest-Priority Interrupt Selector

This block sits inside a multi-processor interrupt controller and decides, for every CPU, which interrupt source it should be told about. Each source carries an 8-bit priority shared by all CPUs. Each source also has its own enable bit and pending bit for every CPU. A source takes part in the choice for a CPU only when both of those bits are set. Among the sources that take part, the one with the smallest priority value wins. When two sources have the same priority value, the one with the lower ID wins.

The winner is then filtered twice. First it is compared with the CPU's priority mask. If it passes, it is reported as the CPU's highest-pending ID; if it fails, the ID reads as 1023, the spurious value. Second, a visible winner is compared with the CPU's running priority. Only if it passes this comparison as well is the CPU's request line raised. The running priority is 9 bits wide, and 0x100 means that no interrupt is active. A global distributor enable and a per-CPU interface enable both gate the result.

The search runs as a balanced comparator tree for each CPU, followed by one register stage. A second register stage holds the filtered outputs. Results therefore appear two clock edges after the inputs, and a valid flag shows when the output registers hold data taken from real inputs.

Top module: `irq_prio_select`

## Requirements
- R1: While reset is asserted, every request line is 0, every highest-pending ID is 1023 and the valid flag is 0.
- R2: Outputs reflect the inputs sampled two rising edges earlier. After only one edge, the previous result is still shown. The valid flag is 0 after the first edge following reset release and 1 from the second edge on.
- R3: A source competes for CPU c only if both its enable bit and its pending bit for c are 1. These bits sit at index c*N_SRC+s of the flattened vectors.
- R4: Among the competing sources, the one with the numerically smallest priority wins. The priority of source s is `src_prio[s*8 +: 8]`.
- R5: On equal priority values, the lowest source ID wins.
- R6: With no competing source, the highest-pending ID is 1023 and the request line is 0.
- R7: The winner is shown as highest-pending only if its priority is strictly below the CPU's mask `prio_mask[c*8 +: 8]`. When the priority equals the mask or is above it, the ID is 1023 and the request line is 0.
- R8: The request line is 1 only for a visible winner whose priority is strictly below the CPU's 9-bit running priority `run_prio[c*9 +: 9]`. A running priority of 0x100 lets any visible winner through.
- R9: If `dist_en` is 0, or the CPU's `cpu_en` bit is 0, that CPU shows ID 1023 and its request line is 0.
- R10: The result for each CPU depends only on that CPU's enable, pending, mask, running-priority and interface-enable inputs, together with the shared priorities and `dist_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dist_en | input | 1 | Global distributor enable |
| cpu_en | input | N_CPU | Interface enable, one bit per CPU |
| src_en | input | N_CPU*N_SRC | Enable bits, index c*N_SRC+s |
| src_pend | input | N_CPU*N_SRC | Pending bits, index c*N_SRC+s |
| src_prio | input | N_SRC*8 | Priority of each source, 8 bits per source |
| prio_mask | input | N_CPU*8 | Priority mask of each CPU |
| run_prio | input | N_CPU*9 | Running priority of each CPU; 0x100 means idle |
| hp_id | output | N_CPU*10 | Highest-pending ID of each CPU; 1023 means none |
| irq_req | output | N_CPU | Request line of each CPU |
| out_valid | output | 1 | Set once the output registers hold data from real inputs |

## Verification
The cases that are hardest to reach are exact boundaries: several sources tying at the lowest priority, and a winner whose priority equals the mask or the running priority exactly. Uniform random priorities almost never produce these. The sweep therefore draws priorities from a set of four closely spaced values. It draws masks and running priorities from those same values and their immediate neighbours, plus 0 and 0x100. As a result, ties and equal-value comparisons occur in a large share of the vectors. Directed vectors then pin each boundary down on its own, and one directed vector changes the inputs and samples after a single edge to expose the latency.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
    localparam int PRIO_W = 8;
    localparam int RUN_W  = PRIO_W + 1;
    localparam int ID_W   = 10;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

    // stage-1 record: tree winner plus the filter operands captured alongside it
    typedef struct packed {
        logic              found;
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
        logic              gate;
        logic [PRIO_W-1:0] mask;
        logic [RUN_W-1:0]  run;
    } win_t;

    typedef struct packed {
        logic [ID_W-1:0] hp;
        logic            req;
    } res_t;
endpackage

// File: rtl/irqsel_tree.sv
module irqsel_tree
    import irqsel_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic [N_SRC-1:0]        cand,
    input  logic [N_SRC*PRIO_W-1:0] prio,
    output logic                    win_found,
    output logic [ID_W-1:0]         win_id,
    output logic [PRIO_W-1:0]       win_prio
);
    localparam int LEVELS = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam int LEAVES = 1 << LEVELS;
    localparam int NODES  = 2 * LEAVES - 1;

    logic              nd_vld [NODES];
    logic [ID_W-1:0]   nd_id  [NODES];
    logic [PRIO_W-1:0] nd_pr  [NODES];

    // leaves in ascending ID order, left to right
    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < N_SRC) begin : g_real
            assign nd_vld[LEAVES-1+i] = cand[i];
            assign nd_id[LEAVES-1+i]  = ID_W'(i);
            assign nd_pr[LEAVES-1+i]  = prio[i*PRIO_W +: PRIO_W];
        end else begin : g_pad
            assign nd_vld[LEAVES-1+i] = 1'b0;
            assign nd_id[LEAVES-1+i]  = '0;
            assign nd_pr[LEAVES-1+i]  = '0;
        end
    end

    // left child holds lower IDs, so it keeps the win on a tie
    for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
        logic take_left;
        assign take_left = nd_vld[2*k+1] &&
                           (!nd_vld[2*k+2] || (nd_pr[2*k+1] <= nd_pr[2*k+2]));
        assign nd_vld[k] = nd_vld[2*k+1] || nd_vld[2*k+2];
        assign nd_id[k]  = take_left ? nd_id[2*k+1] : nd_id[2*k+2];
        assign nd_pr[k]  = take_left ? nd_pr[2*k+1] : nd_pr[2*k+2];
    end

    assign win_found = nd_vld[0];
    assign win_id    = nd_id[0];
    assign win_prio  = nd_pr[0];
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
    import irqsel_pkg::*;
#(
    parameter int N_CPU = 2,
    parameter int N_SRC = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dist_en,
    input  logic [N_CPU-1:0]        cpu_en,
    input  logic [N_CPU*N_SRC-1:0]  src_en,
    input  logic [N_CPU*N_SRC-1:0]  src_pend,
    input  logic [N_SRC*PRIO_W-1:0] src_prio,
    input  logic [N_CPU*PRIO_W-1:0] prio_mask,
    input  logic [N_CPU*RUN_W-1:0]  run_prio,
    output logic [N_CPU*ID_W-1:0]   hp_id,
    output logic [N_CPU-1:0]        irq_req,
    output logic                    out_valid
);
    typedef struct packed {
        win_t [N_CPU-1:0] s1;
        res_t [N_CPU-1:0] res;
        logic [1:0]       vld;
    } state_t;

    state_t st_d, st_q;

    logic [N_CPU-1:0] tr_found;
    logic [ID_W-1:0]   tr_id [N_CPU];
    logic [PRIO_W-1:0] tr_pr [N_CPU];

    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
        irqsel_tree #(.N_SRC(N_SRC)) u_tree (
            .cand      (src_en[c*N_SRC +: N_SRC] & src_pend[c*N_SRC +: N_SRC]),
            .prio      (src_prio),
            .win_found (tr_found[c]),
            .win_id    (tr_id[c]),
            .win_prio  (tr_pr[c])
        );
        assign hp_id[c*ID_W +: ID_W] = st_q.res[c].hp;
        assign irq_req[c]            = st_q.res[c].req;
    end

    assign out_valid = st_q.vld[1];

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < N_CPU; c++) begin
            logic visible;
            // stage 1: capture winner and its filter operands
            st_d.s1[c].found = tr_found[c];
            st_d.s1[c].id    = tr_id[c];
            st_d.s1[c].prio  = tr_pr[c];
            st_d.s1[c].gate  = dist_en & cpu_en[c];
            st_d.s1[c].mask  = prio_mask[c*PRIO_W +: PRIO_W];
            st_d.s1[c].run   = run_prio[c*RUN_W +: RUN_W];
            // stage 2: mask filter, then running-priority filter
            visible = st_q.s1[c].gate && st_q.s1[c].found &&
                      (st_q.s1[c].prio < st_q.s1[c].mask);
            st_d.res[c].hp  = visible ? st_q.s1[c].id : SPURIOUS_ID;
            st_d.res[c].req = visible && ({1'b0, st_q.s1[c].prio} < st_q.s1[c].run);
        end
        st_d.vld = {st_q.vld[0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < N_CPU; c++) begin
                st_q.s1[c]      <= '0;
                st_q.res[c].hp  <= SPURIOUS_ID;
                st_q.res[c].req <= 1'b0;
            end
            st_q.vld <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/irqsel_checker.sv
module irqsel_checker
    import irqsel_pkg::*;
#(
    parameter int N_CPU = 2,
    parameter int N_SRC = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    dist_en,
    input logic [N_CPU-1:0]        cpu_en,
    input logic [N_CPU*N_SRC-1:0]  src_en,
    input logic [N_CPU*N_SRC-1:0]  src_pend,
    input logic [N_SRC*PRIO_W-1:0] src_prio,
    input logic [N_CPU*PRIO_W-1:0] prio_mask,
    input logic [N_CPU*RUN_W-1:0]  run_prio,
    input logic [N_CPU*ID_W-1:0]   hp_id,
    input logic [N_CPU-1:0]        irq_req,
    input logic                    out_valid
);
    logic [N_CPU*N_SRC-1:0] qual_p1, qual_p2;
    logic [N_CPU-1:0]       gate_p1, gate_p2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qual_p1 <= '0; qual_p2 <= '0;
            gate_p1 <= '0; gate_p2 <= '0;
        end else begin
            qual_p1 <= src_en & src_pend;
            qual_p2 <= qual_p1;
            gate_p1 <= cpu_en & {N_CPU{dist_en}};
            gate_p2 <= gate_p1;
        end
    end

    p_valid_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> out_valid);

    for (genvar c = 0; c < N_CPU; c++) begin : g_chk
        logic [ID_W-1:0] hp;
        assign hp = hp_id[c*ID_W +: ID_W];

        p_req_needs_hp_r8: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req[c] |-> (hp != SPURIOUS_ID));

        p_id_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (hp == SPURIOUS_ID) || (hp < ID_W'(N_SRC)));

        p_hp_qualified_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && hp != SPURIOUS_ID && hp < ID_W'(N_SRC))
                |-> qual_p2[c*N_SRC + int'(hp)]);

        p_gate_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !gate_p2[c]) |-> (hp == SPURIOUS_ID && !irq_req[c]));
    end
endmodule

bind irq_prio_select irqsel_checker #(.N_CPU(N_CPU), .N_SRC(N_SRC)) u_chk (.*);

// File: tb/irq_prio_select_tb.sv
`timescale 1ns/1ps
module irq_prio_select_tb;
    localparam int NC = 2;
    localparam int NS = 8;
    localparam int PW = 8;
    localparam int RW = 9;
    localparam int IW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dist_en;
    logic [NC-1:0]    cpu_en;
    logic [NC*NS-1:0] src_en, src_pend;
    logic [NS*PW-1:0] src_prio;
    logic [NC*PW-1:0] prio_mask;
    logic [NC*RW-1:0] run_prio;
    logic [NC*IW-1:0] hp_id;
    logic [NC-1:0]    irq_req;
    logic             out_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    irq_prio_select #(.N_CPU(NC), .N_SRC(NS)) u_dut (.*);

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int hp_of(int c);
        return int'(hp_id[c*IW +: IW]);
    endfunction

    // expected result from the requirements
    function automatic void model(int c, output int hp, output int req);
        int best_p = 256;
        int best_i = 1023;
        int mk, rn;
        for (int s = 0; s < NS; s++) begin
            if (src_en[c*NS+s] && src_pend[c*NS+s] &&
                int'(src_prio[s*PW +: PW]) < best_p) begin
                best_p = int'(src_prio[s*PW +: PW]);
                best_i = s;
            end
        end
        mk = int'(prio_mask[c*PW +: PW]);
        rn = int'(run_prio[c*RW +: RW]);
        hp = 1023; req = 0;
        if (dist_en && cpu_en[c] && best_p < mk) begin
            hp = best_i;
            req = (best_p < rn) ? 1 : 0;
        end
    endfunction

    task automatic settle_check(string tag);
        int ehp, ereq;
        @(posedge clk); @(posedge clk); @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            model(c, ehp, ereq);
            check($sformatf("%s cpu%0d hp", tag, c), hp_of(c), ehp);
            check($sformatf("%s cpu%0d req", tag, c), int'(irq_req[c]), ereq);
        end
    endtask

    task automatic base_cfg();
        dist_en = 1'b1; cpu_en = '1;
        src_en = '1; src_pend = '0;
        for (int s = 0; s < NS; s++) src_prio[s*PW +: PW] = 8'h80;
        prio_mask = {NC{8'hFF}};
        run_prio  = {NC{9'h100}};
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        base_cfg();
        src_pend = '1;
        repeat (3) @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            check("R1 reset hp", hp_of(c), 1023);
            check("R1 reset req", int'(irq_req[c]), 0);
        end
        check("R1 reset valid", int'(out_valid), 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R2 valid after one edge", int'(out_valid), 0);
        @(posedge clk); @(negedge clk);
        check("R2 valid after two edges", int'(out_valid), 1);

        // R6: nothing pending
        base_cfg();
        settle_check("R6 none pending");
        check("R6 directed hp", hp_of(0), 1023);

        // R3 / R10: pending without enable on cpu0, with enable on cpu1
        base_cfg();
        src_en = '0; src_en[NS+3] = 1'b1;
        src_pend[3] = 1'b1; src_pend[NS+3] = 1'b1;
        settle_check("R3 enable and pending");
        check("R3 cpu0 disabled source", hp_of(0), 1023);
        check("R10 cpu1 own enable", hp_of(1), 3);

        // R4: lowest value wins
        base_cfg();
        src_pend = '1;
        src_prio[6*PW +: PW] = 8'h10;
        settle_check("R4 lowest value");
        check("R4 directed", hp_of(0), 6);

        // R5: tie resolves to lowest ID
        base_cfg();
        src_pend = '1;
        src_prio[5*PW +: PW] = 8'h40; src_prio[2*PW +: PW] = 8'h40;
        settle_check("R5 tie");
        check("R5 directed", hp_of(1), 2);

        // R2 latency: change winner, sample after one edge then two
        src_prio[4*PW +: PW] = 8'h08;
        @(posedge clk); @(negedge clk);
        check("R2 old result after one edge", hp_of(1), 2);
        @(posedge clk); @(negedge clk);
        check("R2 new result after two edges", hp_of(1), 4);

        // R7: mask equal hides, mask one above shows
        base_cfg();
        src_pend[1] = 1'b1; src_prio[1*PW +: PW] = 8'h30;
        prio_mask[0 +: PW] = 8'h30;
        settle_check("R7 mask equal");
        check("R7 equal hides", hp_of(0), 1023);
        prio_mask[0 +: PW] = 8'h31;
        settle_check("R7 mask above");
        check("R7 above shows", hp_of(0), 1);

        // R8: running equal blocks request, idle running passes
        run_prio[0 +: RW] = 9'h030;
        settle_check("R8 running equal");
        check("R8 hp still visible", hp_of(0), 1);
        check("R8 req blocked", int'(irq_req[0]), 0);
        run_prio[0 +: RW] = 9'h100;
        settle_check("R8 running idle");
        check("R8 req raised", int'(irq_req[0]), 1);

        // R9 / R10: gating
        base_cfg();
        src_pend = '1;
        cpu_en[1] = 1'b0;
        settle_check("R9 cpu enable off");
        check("R10 cpu0 unaffected", int'(irq_req[0]), 1);
        check("R9 cpu1 gated", int'(irq_req[1]), 0);
        dist_en = 1'b0; cpu_en = '1;
        settle_check("R9 distributor off");

        // R4 sweep with clustered priorities to hit ties and boundaries
        for (int v = 0; v < 3000; v++) begin
            logic [7:0] pset [4] = '{8'h20, 8'h21, 8'h22, 8'h30};
            logic [7:0] mset [8] = '{8'h20, 8'h21, 8'h22, 8'h23, 8'h30, 8'h31, 8'hFF, 8'h00};
            logic [8:0] rset [6] = '{9'h020, 9'h021, 9'h022, 9'h031, 9'h100, 9'h000};
            @(negedge clk);
            dist_en = ($urandom % 8) != 0;
            for (int c = 0; c < NC; c++) begin
                cpu_en[c] = ($urandom % 8) != 0;
                prio_mask[c*PW +: PW] = mset[$urandom % 8];
                run_prio[c*RW +: RW]  = rset[$urandom % 6];
            end
            for (int s = 0; s < NS; s++) src_prio[s*PW +: PW] = pset[$urandom % 4];
            src_en   = NC*NS'($urandom) | NC*NS'($urandom);
            src_pend = NC*NS'($urandom) & NC*NS'($urandom | $urandom);
            settle_check("R4 sweep");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule